// File: doc/BRIEF.md
# SPI Slave Serial Engine

This block is the serial half of an SPI slave. It runs on the system clock and is steered by an external master through three inputs: serial clock, data in and one active-low select. It never starts a transfer itself. Once select goes low, the first bit of the preloaded transmit word is already on `miso_o`. Each later serial clock edge either moves the next transmit bit out or takes the next receive bit in. The engine sends and receives at the same time.

Transmit words come from a holding register outside the block, which offers a word with `tx_valid_i`. The engine takes a word when its shift register is empty and no word is in progress, or at the moment a word completes. A received word goes to the register block with a one-cycle strobe. The three serial inputs pass through two-flop synchronizers. Serial clock edges are found from the synchronized level, so the system clock must run at least eight times faster than the serial clock.

Clock polarity, clock phase, bit order and word width are parameters, and they must match the master. When the block is deselected, `miso_o` is not released to high impedance. Any three-state buffer belongs outside the block and is controlled by the select line.

Top module: `spi_slave_engine`

## Requirements
- R1: While the synchronized select is high, serial clock and data-in activity has no effect. `rx_valid_o` stays low, `rx_data_o` keeps its value and the transmit register does not shift.
- R2: With select low and a word loaded, `miso_o` shows that word's first bit before any serial clock edge. The first bit is bit DATA_W-1 when LSB_FIRST=0 and bit 0 when LSB_FIRST=1.
- R3: The leading edge of the serial clock is rising when CPOL=0 and falling when CPOL=1. With CPHA=0, data in is sampled on leading edges and `miso_o` advances on trailing edges. With CPHA=1, the two roles swap. The first shift-edge of a word never advances `miso_o`.
- R4: After DATA_W samples, `rx_data_o` holds the received word and `rx_valid_o` is high for exactly one cycle. The first bit received lands in bit DATA_W-1 when LSB_FIRST=0 and in bit 0 when LSB_FIRST=1.
- R5: Within one selection, every bit position carries a transmit bit on `miso_o` and a receive bit from `mosi_i` at the same time, so the master reads back the whole loaded word.
- R6: At word completion, if `tx_valid_i` is high, the transmit register reloads from `tx_data_i` and `tx_take_o` pulses. If it is low, the register empties and the next word is sent as all zeros.
- R7: When the transmit register is empty and no bit of the current word has been sampled, a word offered on `tx_valid_i` is taken at once, with a `tx_take_o` pulse, and no serial clock is needed.
- R8: Raising select partway through a word discards the partial bits with no `rx_valid_o`, drops the unsent transmit bits, and starts the next selection at bit count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master, never high impedance |
| tx_data_i | input | DATA_W | Word offered by the holding register |
| tx_valid_i | input | 1 | Holding register has a word waiting |
| tx_take_o | output | 1 | One-cycle pulse: the offered word was loaded |
| rx_data_o | output | DATA_W | Last complete received word |
| rx_valid_o | output | 1 | One-cycle pulse: `rx_data_o` was updated |

## Verification
The handoff of a finished receive word and the reload of the transmit register from the holding register happen on the same sample edge. The bench provokes this by holding two words in the holding model and running two words back to back under one select. It judges the result by the bits the master reads during the second word and by the receive history, which must show both incoming words in order. A further frame with the holding register empty shows that the same edge empties the register, so the next word is sent as zeros.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic sample;
    logic shift;
  } spi_edge_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned       WIDTH   = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[s-1].q;
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/spi_edge_detect.sv
module spi_edge_detect
  import spi_slave_pkg::*;
#(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_s_i,
  input  logic      active_i,
  output spi_edge_t edge_o
);
  logic prev_q;
  logic rise, fall, lead, trail;

  // keep tracking while idle so selection never sees a stale edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= CPOL;
    else         prev_q <= sclk_s_i;

  assign rise = sclk_s_i & ~prev_q;
  assign fall = ~sclk_s_i & prev_q;

  if (CPOL) begin : g_lead_fall
    assign lead  = fall;
    assign trail = rise;
  end else begin : g_lead_rise
    assign lead  = rise;
    assign trail = fall;
  end

  if (CPHA) begin : g_ph1
    assign edge_o.sample = active_i & trail;
    assign edge_o.shift  = active_i & lead;
  end else begin : g_ph0
    assign edge_o.sample = active_i & lead;
    assign edge_o.shift  = active_i & trail;
  end

  a_r3_sample_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o.sample |=> !edge_o.sample);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          LSB_FIRST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  spi_edge_t         edge_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              miso_o,
  output logic              tx_take_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam int unsigned ACC_W = (DATA_W > 1) ? DATA_W - 1 : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  rx_acc_q, rx_acc_nxt;
  logic [DATA_W-1:0] rx_next, tx_sh_q, tx_shifted;
  logic              tx_full_q, last_bit, load;

  if (DATA_W == 1) begin : g_w1
    assign rx_next    = mosi_i;
    assign rx_acc_nxt = rx_acc_q;
    assign tx_shifted = 1'b0;
    assign miso_o     = tx_sh_q[0];
  end else if (LSB_FIRST) begin : g_lsb
    assign rx_next    = {mosi_i, rx_acc_q};
    assign rx_acc_nxt = rx_next[DATA_W-1:1];
    assign tx_shifted = {1'b0, tx_sh_q[DATA_W-1:1]};
    assign miso_o     = tx_sh_q[0];
  end else begin : g_msb
    assign rx_next    = {rx_acc_q, mosi_i};
    assign rx_acc_nxt = rx_next[ACC_W-1:0];
    assign tx_shifted = {tx_sh_q[DATA_W-2:0], 1'b0};
    assign miso_o     = tx_sh_q[DATA_W-1];
  end

  assign last_bit = (cnt_q == LAST);
  assign load = tx_valid_i &
                ((active_i & edge_i.sample & last_bit) | (~tx_full_q & (cnt_q == '0)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rx_acc_q   <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      tx_sh_q    <= '0;
      tx_full_q  <= 1'b0;
      tx_take_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_take_o  <= load;
      if (!active_i) begin
        cnt_q    <= '0;
        rx_acc_q <= '0;
        if (cnt_q != '0) begin  // aborted word: drop the rest
          tx_full_q <= 1'b0;
          tx_sh_q   <= '0;
        end
      end else begin
        if (edge_i.sample) begin
          rx_acc_q <= rx_acc_nxt;
          if (last_bit) begin
            cnt_q      <= '0;
            rx_data_o  <= rx_next;
            rx_valid_o <= 1'b1;
            tx_full_q  <= 1'b0;
            tx_sh_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        // first shift-edge of a word keeps the first bit in place
        if (edge_i.shift && cnt_q != '0) tx_sh_q <= tx_shifted;
      end
      if (load) begin
        tx_sh_q   <= tx_data_i;
        tx_full_q <= 1'b1;
      end
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(DATA_W));
  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> ($stable(rx_data_o) && !rx_valid_o));
  a_r6_take_needs_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o |-> $past(tx_valid_i));
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter bit          CPOL        = 1'b0,
  parameter bit          CPHA        = 1'b0,
  parameter bit          LSB_FIRST   = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_take_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam logic [2:0] SYNC_RST = {1'b1, CPOL, 1'b0};

  logic [2:0] pins_s;
  logic       active;
  spi_edge_t  edges;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  assign active = ~pins_s[2];

  spi_edge_detect #(.CPOL(CPOL), .CPHA(CPHA)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[1]),
    .active_i(active),
    .edge_o  (edges)
  );

  spi_shift_core #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .edge_i    (edges),
    .mosi_i    (pins_s[0]),
    .tx_data_i (tx_data_i),
    .tx_valid_i(tx_valid_i),
    .miso_o    (miso_o),
    .tx_take_o (tx_take_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );
endmodule

// File: tb/spi_slave_engine_tb.sv
module spi_slave_engine_tb;
  localparam int H = 8;  // half serial period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] sclk_b = 2'b10, mosi_b = 2'b00, ss_b = 2'b11;
  logic [1:0] miso_b;

  // main instance holding model: queue of words
  logic [7:0] hq [0:7];
  int hq_n = 0, hq_i = 0, takes0 = 0;
  logic [7:0] tx_data0;
  logic tx_valid0, take0, rxv0;
  logic [7:0] rx0;
  assign tx_valid0 = (hq_i < hq_n);
  assign tx_data0  = hq[hq_i[2:0]];

  logic [7:0] tx_data1 = 8'h00;
  logic tx_valid1 = 1'b0, take1, rxv1;
  logic [7:0] rx1;
  int takes1 = 0;

  logic [7:0] h0 [0:15];
  logic [7:0] h1 [0:15];
  int rxc0 = 0, rxc1 = 0;

  int errors = 0, checks = 0;
  logic [7:0] mw [0:3];
  logic [7:0] mr [0:3];

  spi_slave_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk_b[0]), .mosi_i(mosi_b[0]), .ss_ni(ss_b[0]),
    .miso_o(miso_b[0]), .tx_data_i(tx_data0), .tx_valid_i(tx_valid0), .tx_take_o(take0),
    .rx_data_o(rx0), .rx_valid_o(rxv0)
  );

  spi_slave_engine #(.DATA_W(8), .CPOL(1'b1), .CPHA(1'b1), .LSB_FIRST(1'b1)) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk_b[1]), .mosi_i(mosi_b[1]), .ss_ni(ss_b[1]),
    .miso_o(miso_b[1]), .tx_data_i(tx_data1), .tx_valid_i(tx_valid1), .tx_take_o(take1),
    .rx_data_o(rx1), .rx_valid_o(rxv1)
  );

  always @(negedge clk) begin
    if (take0) begin hq_i = hq_i + 1; takes0 = takes0 + 1; end
    if (take1) begin tx_valid1 = 1'b0; takes1 = takes1 + 1; end
    if (rxv0) begin h0[rxc0[3:0]] = rx0; rxc0 = rxc0 + 1; end
    if (rxv1) begin h1[rxc1[3:0]] = rx1; rxc1 = rxc1 + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master: nw words from mw, read into mr; abort after ab bits if ab>0
  task automatic frame(input int sel, input bit cpol, input bit cpha, input bit lsb,
                       input int nw, input int ab);
    int nb = 0;
    ss_b[sel] = 1'b0;
    waitc(H);
    for (int w = 0; w < nw; w++) begin
      mr[w] = 8'h00;
      for (int i = 0; i < 8; i++) begin
        int idx = lsb ? i : 7 - i;
        if (ab > 0 && nb == ab) break;
        nb++;
        if (!cpha) begin
          mosi_b[sel] = mw[w][idx];
          waitc(H);
          mr[w][idx] = miso_b[sel];
          sclk_b[sel] = ~cpol;
          waitc(H);
          sclk_b[sel] = cpol;
        end else begin
          sclk_b[sel] = ~cpol;
          mosi_b[sel] = mw[w][idx];
          waitc(H);
          mr[w][idx] = miso_b[sel];
          sclk_b[sel] = cpol;
          waitc(H);
        end
      end
    end
    waitc(H);
    ss_b[sel] = 1'b1;
    waitc(4 * H);
  endtask

  task automatic t_reset;
    check(miso_b[0] == 1'b0, "reset miso", miso_b[0], 0);
    check(rxv0 == 1'b0 && take0 == 1'b0, "reset strobes", {rxv0, take0}, 0);
    check(rx0 == 8'h00, "reset rx_data", rx0, 0);
    check(miso_b[1] == 1'b0, "reset alt miso", miso_b[1], 0);
  endtask

  task automatic t_ignore;  // R1
    for (int k = 0; k < 16; k++) begin
      sclk_b[0] = ~sclk_b[0];
      mosi_b[0] = k[1];
      waitc(H);
    end
    waitc(H);
    check(rxc0 == 0, "R1 no rx_valid when deselected", rxc0, 0);
    check(rx0 == 8'h00, "R1 rx_data unchanged", rx0, 0);
    check(miso_b[0] == 1'b0, "R1 miso unchanged", miso_b[0], 0);
  endtask

  task automatic t_basic;  // R7 R2 R3 R4 R5
    hq[0] = 8'hA5; hq_n = 1;
    waitc(5);
    check(takes0 == 1, "R7 idle take without sclk", takes0, 1);
    ss_b[0] = 1'b0;
    waitc(4);
    check(miso_b[0] == 1'b1, "R2 first bit (msb) before any edge", miso_b[0], 1);
    mw[0] = 8'h3C;
    frame(0, 1'b0, 1'b0, 1'b0, 1, 0);
    check(mr[0] == 8'hA5, "R5 R3 master reads loaded word", mr[0], 8'hA5);
    check(rxc0 == 1, "R4 one rx_valid pulse", rxc0, 1);
    check(h0[0] == 8'h3C, "R4 received word", h0[0], 8'h3C);
  endtask

  task automatic t_b2b;  // R6
    hq[1] = 8'h96; hq[2] = 8'h5A; hq_n = 3;
    waitc(5);
    check(takes0 == 2, "R7 second idle take", takes0, 2);
    mw[0] = 8'hC3; mw[1] = 8'h0F;
    frame(0, 1'b0, 1'b0, 1'b0, 2, 0);
    check(mr[0] == 8'h96, "R6 first word out", mr[0], 8'h96);
    check(mr[1] == 8'h5A, "R6 reload at completion", mr[1], 8'h5A);
    check(takes0 == 3, "R6 take pulse at completion", takes0, 3);
    check(rxc0 == 3 && h0[1] == 8'hC3, "R4 first b2b rx", h0[1], 8'hC3);
    check(h0[2] == 8'h0F, "R4 second b2b rx", h0[2], 8'h0F);
  endtask

  task automatic t_empty;  // R6
    mw[0] = 8'h81;
    frame(0, 1'b0, 1'b0, 1'b0, 1, 0);
    check(mr[0] == 8'h00, "R6 empty register sends zeros", mr[0], 0);
    check(rxc0 == 4 && h0[3] == 8'h81, "R5 rx while sending zeros", h0[3], 8'h81);
  endtask

  task automatic t_abort;  // R8
    mw[0] = 8'hFF;
    frame(0, 1'b0, 1'b0, 1'b0, 1, 3);
    check(rxc0 == 4, "R8 no rx_valid on aborted word", rxc0, 4);
    hq[3] = 8'hE7; hq_n = 4;
    waitc(5);
    mw[0] = 8'h24;
    frame(0, 1'b0, 1'b0, 1'b0, 1, 0);
    check(mr[0] == 8'hE7, "R8 fresh word after abort", mr[0], 8'hE7);
    check(rxc0 == 5 && h0[4] == 8'h24, "R8 rx count restarts", h0[4], 8'h24);
  endtask

  task automatic t_alt;  // R2 R3 R4 lsb-first, cpol=1 cpha=1
    tx_data1 = 8'h4B; tx_valid1 = 1'b1;
    waitc(5);
    check(takes1 == 1, "R7 alt idle take", takes1, 1);
    ss_b[1] = 1'b0;
    waitc(4);
    check(miso_b[1] == 1'b1, "R2 alt first bit (lsb)", miso_b[1], 1);
    mw[0] = 8'hD2;
    frame(1, 1'b1, 1'b1, 1'b1, 1, 0);
    check(mr[0] == 8'h4B, "R3 alt mode master reads word", mr[0], 8'h4B);
    check(rxc1 == 1 && h1[0] == 8'hD2, "R4 alt lsb-first rx", h1[0], 8'hD2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    waitc(4);
    rst_n = 1'b1;
    waitc(3);
    t_reset();
    t_ignore();
    t_basic();
    t_b2b();
    t_empty();
    t_abort();
    t_alt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule